// File: doc/BRIEF.md
# Known-Answer Self-Test Sequencer

This block guards a crypto subsystem at start-up. When hardware reset is released, it works through seven known-answer test steps on its own, with no host command. Each step uses a start/done/result handshake with one engine. The block compares every returned result with an answer constant that is built into the logic. While the run is in progress, every service request is denied and the data-movement enable stays low.

If all seven steps succeed, the block enters a pass state. It then grants service requests and raises the data-movement enable. A single mismatch, or a step that does not answer within a programmable number of cycles, locks the block in an error state. Only the hardware reset clears that state. It also records which step failed. Software can set a rerun bit while the block is in the pass state; this behaves like a reset and repeats the whole sequence.

The engines and their test vectors are outside this block. Each step is just a start pulse, a done pulse, a result word and a constant.

Top module: `kat_sequencer`

## Requirements
- R1: One cycle after reset is released, the block starts its run by itself. It shows busy_o=1, pass_o=0 and error_o=0 from reset onward, and it raises the first start pulse, for step 0, in the second cycle after release.
- R2: The steps run strictly in index order, one at a time: 0 AES-ECB encrypt, 1 AES-ECB decrypt, 2 HMAC-SHA-1, 3 HMAC-SHA-256, 4 HMAC-SHA-512, 5 ECDSA P-256 sign, 6 ECDSA P-256 verify. Bit i of step_start_o is a one-cycle pulse for step i, at most one bit is high at a time, and the next start follows one cycle after the accepted done of the previous step.
- R3: The result of step i is the slice step_result_i[i*RES_W +: RES_W]. Its known answer is the low RES_W bits of ((i+1)*0x9E3779B9) XOR 0x5A5A0F0F. A done with any other value moves the block into error on the next cycle, with fail_idx_o=i.
- R4: In the cycles after a start, the step's done is accepted while the wait counter, which starts at 0, is at most tmo_limit_i. If done is still missing when the counter equals tmo_limit_i, the block enters error with fail_idx_o set to that step. A done that arrives exactly tmo_limit_i+1 cycles after the start pulse is still accepted.
- R5: The error state, together with fail_idx_o, holds until the hardware reset. rerun_i has no effect in that state.
- R6: svc_grant_o equals svc_req_i when pass_o=1 and is 0 otherwise. svc_deny_o equals svc_req_i when pass_o=0 and is 0 otherwise. xfer_en_o equals pass_o.
- R7: pass_o becomes 1 only after step 6 completes with a matching result. It is never 1 together with busy_o or error_o.
- R8: rerun_i sampled high in the pass state gives busy_o=1 and pass_o=0 on the next cycle, and the run then restarts from step 0. rerun_i has no effect while busy.
- R9: A done for any step other than the running one is ignored, together with its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| rerun_i | input | 1 | Control bit that requests a full re-test |
| tmo_limit_i | input | TMO_W | Wait-cycle limit for each step |
| step_start_o | output | 7 | Start pulse, one bit per step |
| step_done_i | input | 7 | Done pulse, one bit per step |
| step_result_i | input | 7*RES_W | Result words, step i in slice i |
| svc_req_i | input | NUM_SVC | Service requests |
| svc_grant_o | output | NUM_SVC | Granted requests |
| svc_deny_o | output | NUM_SVC | Refused requests |
| xfer_en_o | output | 1 | Data input/output enable |
| busy_o | output | 1 | Test run in progress |
| pass_o | output | 1 | All steps passed |
| error_o | output | 1 | Latched failure |
| fail_idx_o | output | 3 | Index of the failing step |

## Verification
The assertions assume the following about the environment:
- An engine raises done only for one cycle at a time.
- tmo_limit_i does not change during a run.
- rerun_i is a control bit that is sampled while the block is in a state, not a handshake.

The stimulus keeps within these limits. It holds the limit at 5 for every run and answers each start with a single done pulse after a chosen latency. Stray dones appear only on steps that are not running. Rerun pulses are driven while the block is busy, in pass and in error, to show where they take effect.

// File: rtl/kat_pkg.sv
package kat_pkg;
    localparam int KAT_STEPS = 7;
    localparam int KAT_IDX_W = $clog2(KAT_STEPS);

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_LAUNCH,
        ST_WAIT,
        ST_PASS,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        seq_state_e           state;
        logic [KAT_IDX_W-1:0] idx;
        logic [KAT_IDX_W-1:0] fidx;
    } seq_t;

    // Known answer of a step; the top keeps the low RES_W bits.
    function automatic logic [63:0] kat_answer(input int unsigned step);
        return ((64'(step) + 64'd1) * 64'h9E37_79B9) ^ 64'h5A5A_0F0F;
    endfunction
endpackage

// File: rtl/kat_wait_timer.sv
module kat_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (en_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == limit_i);
endmodule

// File: rtl/kat_answer_check.sv
module kat_answer_check
    import kat_pkg::*;
#(
    parameter int RES_W = 32
) (
    input  logic [KAT_IDX_W-1:0]       idx_i,
    input  logic [KAT_STEPS*RES_W-1:0] result_i,
    output logic                       match_o
);
    logic [KAT_STEPS-1:0] hit;

    for (genvar g = 0; g < KAT_STEPS; g++) begin : g_step
        localparam logic [63:0] ANS = kat_answer(g);
        assign hit[g] = (result_i[g*RES_W +: RES_W] == ANS[RES_W-1:0]);
    end

    assign match_o = hit[idx_i];
endmodule

// File: rtl/kat_service_gate.sv
module kat_service_gate #(
    parameter int NUM_SVC = 4
) (
    input  logic               open_i,
    input  logic [NUM_SVC-1:0] req_i,
    output logic [NUM_SVC-1:0] grant_o,
    output logic [NUM_SVC-1:0] deny_o,
    output logic               xfer_en_o
);
    for (genvar g = 0; g < NUM_SVC; g++) begin : g_lane
        assign grant_o[g] = req_i[g] & open_i;
        assign deny_o[g]  = req_i[g] & ~open_i;
    end
    assign xfer_en_o = open_i;
endmodule

// File: rtl/kat_sequencer.sv
module kat_sequencer
    import kat_pkg::*;
#(
    parameter int RES_W   = 32,
    parameter int TMO_W   = 16,
    parameter int NUM_SVC = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       rerun_i,
    input  logic [TMO_W-1:0]           tmo_limit_i,
    output logic [KAT_STEPS-1:0]       step_start_o,
    input  logic [KAT_STEPS-1:0]       step_done_i,
    input  logic [KAT_STEPS*RES_W-1:0] step_result_i,
    input  logic [NUM_SVC-1:0]         svc_req_i,
    output logic [NUM_SVC-1:0]         svc_grant_o,
    output logic [NUM_SVC-1:0]         svc_deny_o,
    output logic                       xfer_en_o,
    output logic                       busy_o,
    output logic                       pass_o,
    output logic                       error_o,
    output logic [KAT_IDX_W-1:0]       fail_idx_o
);
    localparam logic [KAT_IDX_W-1:0] LAST_IDX = KAT_IDX_W'(KAT_STEPS - 1);
    localparam logic [KAT_STEPS-1:0] ONE_HOT0 = KAT_STEPS'(1);

    seq_t d, q;
    logic timer_clr, timer_en, expired, cur_done, cur_match;

    kat_wait_timer #(.W(TMO_W)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (timer_clr),
        .en_i      (timer_en),
        .limit_i   (tmo_limit_i),
        .expired_o (expired)
    );

    kat_answer_check #(.RES_W(RES_W)) u_check (
        .idx_i    (q.idx),
        .result_i (step_result_i),
        .match_o  (cur_match)
    );

    kat_service_gate #(.NUM_SVC(NUM_SVC)) u_gate (
        .open_i    (pass_o),
        .req_i     (svc_req_i),
        .grant_o   (svc_grant_o),
        .deny_o    (svc_deny_o),
        .xfer_en_o (xfer_en_o)
    );

    assign cur_done = step_done_i[q.idx];

    always_comb begin
        d         = q;
        timer_clr = 1'b0;
        timer_en  = 1'b0;
        case (q.state)
            ST_BOOT: begin
                d.state = ST_LAUNCH;
                d.idx   = '0;
            end
            ST_LAUNCH: begin
                d.state   = ST_WAIT;
                timer_clr = 1'b1;
            end
            ST_WAIT: begin
                if (cur_done) begin
                    if (!cur_match) begin
                        d.state = ST_FAIL;
                        d.fidx  = q.idx;
                    end else if (q.idx == LAST_IDX) begin
                        d.state = ST_PASS;
                    end else begin
                        d.state = ST_LAUNCH;
                        d.idx   = q.idx + 1'b1;
                    end
                end else if (expired) begin
                    d.state = ST_FAIL;
                    d.fidx  = q.idx;
                end else begin
                    timer_en = 1'b1;
                end
            end
            ST_PASS: begin
                if (rerun_i) begin
                    d.state = ST_BOOT;
                    d.idx   = '0;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state <= ST_BOOT;
            q.idx   <= '0;
            q.fidx  <= '0;
        end else begin
            q <= d;
        end
    end

    assign step_start_o = (q.state == ST_LAUNCH) ? (ONE_HOT0 << q.idx) : '0;
    assign busy_o       = (q.state == ST_BOOT) || (q.state == ST_LAUNCH) || (q.state == ST_WAIT);
    assign pass_o       = (q.state == ST_PASS);
    assign error_o      = (q.state == ST_FAIL);
    assign fail_idx_o   = q.fidx;

    // R2: at most one start at a time, and only during a run
    p_start_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(step_start_o));
    p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|step_start_o) |-> busy_o);
    // R3: a wrong answer latches the error
    p_mismatch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_WAIT && cur_done && !cur_match) |=> error_o);
    // R4: an expired wait without done fails the step
    p_timeout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_WAIT && expired && !cur_done) |=> (error_o && fail_idx_o == $past(q.idx)));
    // R5: the error state is permanent
    p_error_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |=> (error_o && $stable(fail_idx_o)));
    // R6: the service path stays shut unless passed
    p_gate_shut_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pass_o |-> (svc_grant_o == '0 && !xfer_en_o));
    // R7: pass excludes busy and error
    p_pass_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_o |-> (!busy_o && !error_o));
    // R8: a rerun from pass restarts the run
    p_rerun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pass_o && rerun_i) |=> (busy_o && !pass_o));
endmodule

// File: tb/sim_kat_sequencer.sv
module sim_kat_sequencer;
    localparam int N  = 7;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rerun = 1'b0;
    logic [15:0]   tmo_limit = 16'd5;
    logic [N-1:0]  step_start;
    logic [N-1:0]  step_done = '0;
    logic [N*RW-1:0] step_result = '0;
    logic [3:0]    svc_req = '0;
    logic [3:0]    svc_grant, svc_deny;
    logic          xfer_en, busy, pass, error;
    logic [2:0]    fail_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    kat_sequencer u0 (
        .clk_i(clk), .rst_ni(rst_n), .rerun_i(rerun), .tmo_limit_i(tmo_limit),
        .step_start_o(step_start), .step_done_i(step_done), .step_result_i(step_result),
        .svc_req_i(svc_req), .svc_grant_o(svc_grant), .svc_deny_o(svc_deny),
        .xfer_en_o(xfer_en), .busy_o(busy), .pass_o(pass), .error_o(error),
        .fail_idx_o(fail_idx)
    );

    function automatic logic [31:0] exp_ans(input int i);
        logic [31:0] k;
        k = 32'(i + 1);
        return (k * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // engine emulation: latency per step (-1 = never answers), corruption, stray dones
    int          lat [N];
    logic [31:0] flip [N];
    bit          stray_en = 0;
    int          pend_idx = 0, pend_cnt = 0;
    bit          pend_on = 0;

    always @(negedge clk) begin
        step_done = '0;
        if (!rst_n) begin
            pend_on = 0;
        end else begin
            if (pend_on) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    step_done[pend_idx] = 1'b1;
                    step_result[pend_idx*RW +: RW] = exp_ans(pend_idx) ^ flip[pend_idx];
                    if (stray_en) begin
                        step_done[(pend_idx + 1) % N] = 1'b1;
                        step_result[((pend_idx + 1) % N)*RW +: RW] = ~exp_ans((pend_idx + 1) % N);
                    end
                    pend_on = 0;
                end
            end
            for (int i = 0; i < N; i++)
                if (step_start[i] && lat[i] >= 0) begin
                    pend_on = 1; pend_idx = i; pend_cnt = lat[i];
                end
        end
    end

    // behavioural reference: 0 boot, 1 launch, 2 wait, 3 pass, 4 error
    int m_ph = 0, m_idx = 0, m_fidx = 0, m_wait = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_fidx = 0; m_wait = 0;
        end else begin
            case (m_ph)
                0: begin m_ph = 1; m_idx = 0; end
                1: begin m_ph = 2; m_wait = 0; end
                2: begin
                    if (step_done[m_idx]) begin
                        if (step_result[m_idx*RW +: RW] == exp_ans(m_idx)) begin
                            if (m_idx == N - 1) m_ph = 3;
                            else begin m_idx++; m_ph = 1; end
                        end else begin m_ph = 4; m_fidx = m_idx; end
                    end else if (m_wait == int'(tmo_limit)) begin
                        m_ph = 4; m_fidx = m_idx;
                    end else m_wait++;
                end
                3: if (rerun) begin m_ph = 0; m_idx = 0; end
                default: ;
            endcase
        end
    end

    // compare every cycle, away from the clock edges
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            logic [N-1:0] e_start;
            e_start = (m_ph == 1) ? (N'(1) << m_idx) : '0;
            check(busy == (m_ph <= 2), "R1 busy", 32'(busy), 32'(m_ph <= 2));
            check(step_start == e_start, "R2 start", 32'(step_start), 32'(e_start));
            check(error == (m_ph == 4) && fail_idx == 3'(m_fidx), "R3 error/idx",
                  {error, 28'd0, fail_idx}, {(m_ph == 4), 28'd0, 3'(m_fidx)});
            check(pass == (m_ph == 3), "R7 pass", 32'(pass), 32'(m_ph == 3));
            check(svc_grant == (svc_req & {4{m_ph == 3}}) && svc_deny == (svc_req & {4{m_ph != 3}})
                  && xfer_en == (m_ph == 3), "R6 gate",
                  {svc_grant, svc_deny, 23'd0, xfer_en}, {svc_req & {4{m_ph == 3}}, svc_req & {4{m_ph != 3}}, 23'd0, 1'(m_ph == 3)});
        end
    end

    task automatic cfg_clean();
        for (int i = 0; i < N; i++) begin lat[i] = 1 + (i % 3); flip[i] = '0; end
        stray_en = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rerun = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #3;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cfg_clean();
        svc_req = 4'b1011;
        // R1: automatic start after reset
        do_reset();
        #3;
        check(busy && !pass && !error && step_start == '0, "R1 after release", {busy, pass, error}, 3'b100);
        settle(1);
        check(step_start == 7'b0000001, "R1 first start", 32'(step_start), 1);
        // R8: rerun while busy is ignored
        @(negedge clk); rerun = 1'b1; @(negedge clk); rerun = 1'b0;
        settle(60);
        check(pass && !busy, "R7 all steps pass", 32'(pass), 1);
        // R8: rerun from pass
        @(negedge clk); rerun = 1'b1; @(negedge clk); rerun = 1'b0;
        #3;
        check(busy && !pass, "R8 rerun restarts", {busy, pass}, 2'b10);
        settle(60);
        check(pass, "R8 rerun completes", 32'(pass), 1);

        // R3: mismatch on step 3
        cfg_clean(); flip[3] = 32'h0000_0100;
        do_reset(); settle(40);
        check(error && fail_idx == 3'd3, "R3 mismatch step 3", {error, fail_idx}, {1'b1, 3'd3});
        // R5: rerun ignored in error, state persists
        @(negedge clk); rerun = 1'b1; @(negedge clk); rerun = 1'b0;
        settle(30);
        check(error && !busy && fail_idx == 3'd3, "R5 error sticky", {error, busy, fail_idx}, {2'b10, 3'd3});

        // R4: boundary latency limit+1 accepted
        cfg_clean(); lat[6] = 6;
        do_reset(); settle(60);
        check(pass, "R4 done at limit accepted", 32'(pass), 1);
        // R4: one cycle later is a timeout
        cfg_clean(); lat[2] = 7;
        do_reset(); settle(40);
        check(error && fail_idx == 3'd2, "R4 late done fails", {error, fail_idx}, {1'b1, 3'd2});
        // R4: engine never answers
        cfg_clean(); lat[0] = -1;
        do_reset(); settle(20);
        check(error && fail_idx == 3'd0, "R4 hung step", {error, fail_idx}, {1'b1, 3'd0});

        // R9: stray dones with bad results on other steps are ignored
        cfg_clean(); stray_en = 1;
        svc_req = 4'b0110;
        do_reset(); settle(60);
        check(pass && !error, "R9 stray done ignored", {pass, error}, 2'b10);
        svc_req = 4'b1111;
        settle(2);
        check(svc_grant == 4'b1111 && svc_deny == 4'b0000, "R6 grant after pass", {svc_grant, svc_deny}, 8'hF0);

        summary();
    end
endmodule